// File: doc/BRIEF.md
# Context Identifier Slot Allocator

This block runs beside one core's translation cache. On every context switch it turns a wide 64-bit context identifier into one of a few hardware address-space ID slots. The request carries the incoming context's identifier and its current flush generation. The block answers with the slot to load, a kernel-view ID and a user-view ID for that slot, and a flag that says whether the slot's cached translations must be flushed before use.

Each slot stores the context that owns it and the generation at which its cached entries were last made current. A context that already owns a slot and brings the same generation keeps its warm entries and gets no flush. A context that owns a slot but brings a different generation gets a flush, and the slot takes the new generation. A context that owns no slot takes the lowest-numbered empty slot. If no slot is empty, it takes the least recently used slot, and that slot is flushed. Every switch makes the chosen slot the most recent one.

Control is a two-state machine. `ST_IDLE` accepts a request. The transition IDLE→RESP happens on the accepting edge, and that same edge registers the answer and updates the slot table. `ST_RESP` presents the answer until the consumer takes it. The transition RESP→IDLE happens on the edge where `rsp_ready` is high. Both states otherwise hold.

Top module: `ctx_slot_alloc`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is 0 and `req_ready` is 1, so the first request after reset lands in slot 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 from the following cycle. While `rsp_valid` is 1, `req_ready` is 0 and the response fields hold steady until an edge with `rsp_ready` high.
- R3: A context that owns no slot, arriving while at least one slot is empty, gets the lowest-numbered empty slot with `rsp_flush` = 1.
- R4: A context that owns a slot whose stored generation equals the request's generation gets that same slot with `rsp_flush` = 0.
- R5: A context that owns a slot whose stored generation differs from the request's gets that slot with `rsp_flush` = 1, and the stored generation becomes the request's. A repeat with that generation then reports `rsp_flush` = 0.
- R6: A context that owns no slot, arriving while all slots are full, takes the least recently used slot with `rsp_flush` = 1. The evicted context no longer owns a slot.
- R7: Every accepted request, hit or miss, makes the selected slot the most recent one. The recency ranks of the slots always form a permutation of 0..NSLOT-1, where rank 0 is the newest.
- R8: `rsp_kern_id` = KERN_BASE + slot and `rsp_user_id` = `rsp_kern_id` + USER_OFFSET (defaults: 1 and 2048, on 12 bits). `rsp_slot` is always below NSLOT (default 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A context switch request is present |
| req_ready | output | 1 | The block can take a request |
| req_ctx | input | CTX_W (64) | Identifier of the incoming context |
| req_gen | input | GEN_W (64) | Current flush generation of that context |
| rsp_valid | output | 1 | The answer is present |
| rsp_ready | input | 1 | The consumer takes the answer |
| rsp_slot | output | SLOT_W (3) | Selected slot number |
| rsp_flush | output | 1 | The slot's cached translations must be flushed |
| rsp_kern_id | output | ID_W (12) | Kernel-view address-space ID |
| rsp_user_id | output | ID_W (12) | User-view address-space ID |

## Verification
On every cycle, the assertions check the handshake timing and the hold of the answer, the ID arithmetic, the rule that no context ever owns two slots, the recency ranks staying a permutation, and the rule that a generation-matching hit produces no flush. Only the bench's scenarios can show which slot is chosen over a long history: the lowest-empty order after reset, eviction of the genuinely oldest slot after hits have refreshed others, and the generation being written back so that a repeat stays warm. The bench does this with a reference model driven by a deterministic sweep over nine contexts and four generations, which is more contexts than there are slots.

// File: rtl/ctx_alloc_pkg.sv
package ctx_alloc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } alloc_state_t;
endpackage

// File: rtl/ctx_slot_match.sv
module ctx_slot_match #(
    parameter int NSLOT  = 6,
    parameter int CTX_W  = 64,
    parameter int SLOT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSLOT-1:0]            slot_used,
    input  logic [NSLOT-1:0][CTX_W-1:0] slot_ctx,
    input  logic [CTX_W-1:0]            probe_ctx,
    output logic                        hit,
    output logic [SLOT_W-1:0]           hit_idx,
    output logic                        has_free,
    output logic [SLOT_W-1:0]           free_idx
);
    logic [NSLOT-1:0] match_vec;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            match_vec[i] = slot_used[i] && (slot_ctx[i] == probe_ctx);
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (!slot_used[i]) begin
                has_free = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    // R6: a context never owns more than one slot
    a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_vec) <= 1);
endmodule

// File: rtl/ctx_slot_age.sv
module ctx_slot_age #(
    parameter int NSLOT  = 6,
    parameter int SLOT_W = 3,
    parameter int AGE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch,
    input  logic [SLOT_W-1:0] touch_idx,
    output logic [SLOT_W-1:0] oldest_idx
);
    logic [NSLOT-1:0][AGE_W-1:0] rank_q;
    logic [NSLOT-1:0][NSLOT-1:0] rank_at;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) rank_q[i] <= AGE_W'(i);
        end else if (touch) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (SLOT_W'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int r = 0; r < NSLOT; r++)
            for (int i = 0; i < NSLOT; i++)
                rank_at[r][i] = (rank_q[i] == AGE_W'(r));
        for (int i = 0; i < NSLOT; i++)
            if (rank_q[i] == AGE_W'(NSLOT - 1)) oldest_idx = SLOT_W'(i);
    end

    generate
        for (genvar r = 0; r < NSLOT; r++) begin : g_rank_chk
            // R7: each rank is held by exactly one slot
            a_r7_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(rank_at[r]) == 1);
        end
    endgenerate

    // R7: the touched slot is newest on the next cycle
    a_r7_touch_newest: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/ctx_slot_alloc.sv
module ctx_slot_alloc
    import ctx_alloc_pkg::*;
#(
    parameter int NSLOT       = 6,
    parameter int CTX_W       = 64,
    parameter int GEN_W       = 64,
    parameter int ID_W        = 12,
    parameter int KERN_BASE   = 1,
    parameter int USER_OFFSET = 2048,
    parameter int SLOT_W      = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [GEN_W-1:0]  req_gen,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic              rsp_flush,
    output logic [ID_W-1:0]   rsp_kern_id,
    output logic [ID_W-1:0]   rsp_user_id
);
    localparam int AGE_W = $clog2(NSLOT);

    alloc_state_t state_q, state_d;
    logic [NSLOT-1:0]            used_q;
    logic [NSLOT-1:0][CTX_W-1:0] ctx_q;
    logic [NSLOT-1:0][GEN_W-1:0] gen_q;
    logic                        accept, hit, has_free, need_flush;
    logic [SLOT_W-1:0]           hit_idx, free_idx, oldest_idx, sel_idx;

    ctx_slot_match #(.NSLOT(NSLOT), .CTX_W(CTX_W), .SLOT_W(SLOT_W)) match_i (
        .clk(clk), .rst_n(rst_n), .slot_used(used_q), .slot_ctx(ctx_q),
        .probe_ctx(req_ctx), .hit(hit), .hit_idx(hit_idx),
        .has_free(has_free), .free_idx(free_idx)
    );

    ctx_slot_age #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .AGE_W(AGE_W)) age_i (
        .clk(clk), .rst_n(rst_n), .touch(accept), .touch_idx(sel_idx),
        .oldest_idx(oldest_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and selection
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        accept     = req_valid && req_ready;
        sel_idx    = hit ? hit_idx : (has_free ? free_idx : oldest_idx);
        need_flush = !hit || (gen_q[hit_idx] != req_gen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q      <= '0;
            ctx_q       <= '0;
            gen_q       <= '0;
            rsp_slot    <= '0;
            rsp_flush   <= 1'b0;
            rsp_kern_id <= '0;
            rsp_user_id <= '0;
        end else if (accept) begin
            used_q[sel_idx] <= 1'b1;
            ctx_q[sel_idx]  <= req_ctx;
            gen_q[sel_idx]  <= req_gen;
            rsp_slot        <= sel_idx;
            rsp_flush       <= need_flush;
            rsp_kern_id     <= ID_W'(KERN_BASE) + ID_W'(sel_idx);
            rsp_user_id     <= ID_W'(KERN_BASE) + ID_W'(sel_idx) + ID_W'(USER_OFFSET);
        end
    end

    // R2: answer follows acceptance by one cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R2: answer held while stalled
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_slot) &&
                                       $stable(rsp_flush) && $stable(rsp_kern_id)));
    // R2: no new request while an answer is pending
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R4: a hit with an equal generation reports no flush
    a_r4_warm_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && gen_q[hit_idx] == req_gen) |=> !rsp_flush);
    // R8: ID arithmetic and slot range
    a_r8_id_map: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_slot < SLOT_W'(NSLOT) &&
                       rsp_kern_id - ID_W'(KERN_BASE) == ID_W'(rsp_slot) &&
                       rsp_user_id - rsp_kern_id == ID_W'(USER_OFFSET)));
endmodule

// File: tb/ctx_slot_alloc_tb_top.sv
module ctx_slot_alloc_tb_top;
    localparam int NS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        rsp_ready = 1'b1;
    logic [63:0] req_ctx = '0;
    logic [63:0] req_gen = '0;
    logic        req_ready, rsp_valid, rsp_flush;
    logic [2:0]  rsp_slot;
    logic [11:0] rsp_kern_id, rsp_user_id;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] m_ctx [NS];
    logic [63:0] m_gen [NS];
    bit          m_used[NS];
    int          m_rank[NS];

    always #2.5 clk = ~clk;

    ctx_slot_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_gen(req_gen), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_slot(rsp_slot), .rsp_flush(rsp_flush),
        .rsp_kern_id(rsp_kern_id), .rsp_user_id(rsp_user_id)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: choose slot, flush and tag per the requirements
    task automatic model(input logic [63:0] c, input logic [63:0] g,
                         output int slot, output bit fl, output string tag);
        int hit = -1, fr = -1, old = 0;
        for (int i = 0; i < NS; i++) begin
            if (m_used[i] && m_ctx[i] == c) hit = i;
            if (!m_used[i] && fr < 0) fr = i;
            if (m_rank[i] == NS - 1) old = i;
        end
        if (hit >= 0) begin
            slot = hit; fl = (m_gen[hit] != g);
            tag = fl ? "R5 stale hit" : "R4 warm hit";
        end else if (fr >= 0) begin
            slot = fr; fl = 1; tag = "R3 empty slot";
        end else begin
            slot = old; fl = 1; tag = "R6/R7 LRU evict";
        end
        for (int i = 0; i < NS; i++)
            if (i != slot && m_rank[i] < m_rank[slot]) m_rank[i]++;
        m_rank[slot] = 0;
        m_used[slot] = 1; m_ctx[slot] = c; m_gen[slot] = g;
    endtask

    task automatic switch_to(input logic [63:0] c, input logic [63:0] g, input int stall);
        int eslot; bit efl; string tag;
        model(c, g, eslot, efl, tag);
        @(negedge clk);
        check("R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_ctx = c; req_gen = g;
        rsp_ready = (stall == 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 valid one cycle later", rsp_valid, 1);
        check({tag, " slot"}, rsp_slot, eslot);
        check({tag, " flush"}, rsp_flush, efl);
        check("R8 kernel id", rsp_kern_id, 1 + eslot);
        check("R8 user id", rsp_user_id, 1 + eslot + 2048);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R2 held while stalled", rsp_valid, 1);
            check("R2 not ready while held", req_ready, 0);
            check("R2 slot stable", rsp_slot, eslot);
        end
        rsp_ready = 1'b1;
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NS; i++) begin
            m_used[i] = 0; m_rank[i] = i; m_ctx[i] = '0; m_gen[i] = '0;
        end
        #12 rst_n = 1'b1;
        @(negedge clk);
        check("R1 no response after reset", rsp_valid, 0);
        check("R1 ready after reset", req_ready, 1);
        // R1/R3: fill in order from slot 0
        for (int k = 0; k < NS; k++) switch_to(64'hC0DE_0000_0000_0000 | k, 0, 0);
        switch_to(64'hC0DE_0000_0000_0002, 0, 0);   // R4
        switch_to(64'hC0DE_0000_0000_0002, 5, 2);   // R5 with stall R2
        switch_to(64'hC0DE_0000_0000_0002, 5, 0);   // R5 repeat warm
        switch_to(64'hBEEF_0000_0000_0001, 1, 0);   // R6 evict slot 0
        switch_to(64'hC0DE_0000_0000_0000, 0, 0);   // R6 evicted ctx misses
        // near-exhaustive sweep: 9 contexts x 4 generations
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            switch_to(64'hA500_0000_0000_0000 | (lfsr % 9), 64'(lfsr[10:9]), (n % 17 == 0) ? 1 : 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule